// File: doc/BRIEF.md
# Coldstart Frame Compression Forwarder

This switch-side block routes startup and clock-synchronization control frames between a small number of ports. Each ingress port offers a frame descriptor (frame type, source master identifier, timestamp) on a valid/ready stream. Each egress port presents a descriptor on its own valid/ready stream, with a bitmask that records which masters contributed to it. Payload storage, the MAC and clock-correction arithmetic sit outside the block.

Coldstart frames are copied at once to every port except the one they arrived on. Coldstart acknowledgements follow a failure-tolerance mode. In multi-failure mode they are copied like coldstart frames. In single-failure mode the first acknowledgement opens a collection window of a fixed number of cycles, and every acknowledgement that arrives inside it is merged into one compressed acknowledgement. At the end of the window that frame goes to all ports. Synchronization frames from masters are always collected in this way, and the merged reply goes to every port, masters and clients alike. Frames of any other type are consumed and dropped. Only one collection window exists at a time. The mode input is sampled only while no window is open.

Top module: `cfcompress_fwd`

## Requirements
- R1: After reset, no egress port presents a frame and no ingress port is ready while no ingress frame is offered.
- R2: A frame of type 1 (coldstart) accepted from port i appears in the cycle after acceptance on every port except i. It keeps its type, source and timestamp, and its mask holds only bit `source`.
- R3: With `mode_single` low, a frame of type 2 (acknowledgement) is copied exactly as in R2.
- R4: With `mode_single` high, acknowledgements are not copied. They produce one frame of type 2 on all ports. Its source and timestamp are those of the first acknowledgement, and its mask is the OR of bit `source` over all merged frames.
- R5: A window opens when its first frame is accepted, at clock edge E. It accepts further frames of its kind up to edge E+WIN_CYCLES, and its merged frame is visible after edge E+WIN_CYCLES+1 when all egress slots are free. A frame that arrives after the window closes starts a new window.
- R6: Frames of type 0 (synchronization) are always merged as in R4 and R5, whatever the mode, and the reply goes to all ports.
- R7: Frames of type 3 are accepted and dropped without producing any egress frame.
- R8: The mode is sampled only while no window is open. A change during an open window does not alter how later frames of that window are handled.
- R9: An egress frame stays unchanged until its port's ready is high. A frame that needs a busy egress slot waits with its ingress ready low.
- R10: At most one ingress ready is high per cycle, and among ports offering frames the lowest index is served first.
- R11: While a window of one kind is open or waiting to be emitted, a frame that would open a window of the other kind waits until the window has been emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_single | input | 1 | 1 = single-failure (merge acknowledgements), 0 = multi-failure |
| in_valid | input | NPORTS | Ingress descriptor valid, one bit per port |
| in_ready | output | NPORTS | Ingress descriptor accepted, one bit per port |
| in_type | input | NPORTS*2 | Frame type per port: 0 sync, 1 coldstart, 2 acknowledgement, 3 other |
| in_src | input | NPORTS*ID_W | Source master identifier per port |
| in_ts | input | NPORTS*TS_W | Timestamp per port |
| out_valid | output | NPORTS | Egress descriptor valid per port |
| out_ready | input | NPORTS | Egress descriptor taken per port |
| out_type | output | NPORTS*2 | Egress frame type per port |
| out_src | output | NPORTS*ID_W | Egress source identifier per port |
| out_ts | output | NPORTS*TS_W | Egress timestamp per port |
| out_mask | output | NPORTS*2**ID_W | Contributing-master bitmask per port |

## Verification
Coldstart frames from different ports separate the copy path from the merge path, and they show that the ingress port is left out. Acknowledgements are sent under each mode and with a mode flip mid-window, which tells a latched mode from a live one. Groups of acknowledgements and synchronization frames inside one window, and again across a window boundary, expose wrong mask merging and an off-by-one window length. Simultaneous offers, held egress slots and a synchronization frame arriving during an acknowledgement window exercise priority, backpressure and the one-window rule.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
   localparam int TYPE_W = 2;

   typedef enum logic [TYPE_W-1:0] {
      FT_SYNC   = 2'd0,
      FT_CSTART = 2'd1,
      FT_CACK   = 2'd2,
      FT_OTHER  = 2'd3
   } ftype_e;

   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_OPEN = 2'd1,
      WS_EMIT = 2'd2
   } wstate_e;
endpackage

// File: rtl/cfc_pick.sv
module cfc_pick #(
   parameter int N         = 4,
   parameter int IDX_W     = 2,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N-1:0]     req_i,
   output logic             vld_o,
   output logic [IDX_W-1:0] idx_o
);
   assign vld_o = |req_i;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx_o = '0;
            for (int k = N-1; k >= 0; k--)
               if (req_i[k]) idx_o = IDX_W'(k);
         end
      end else begin : g_high
         always_comb begin
            idx_o = '0;
            for (int k = 0; k < N; k++)
               if (req_i[k]) idx_o = IDX_W'(k);
         end
      end
   endgenerate
endmodule

// File: rtl/cfc_window.sv
module cfc_window import cfc_pkg::*; #(
   parameter int ID_W       = 3,
   parameter int TS_W       = 16,
   parameter int WIN_CYCLES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 open_i,
   input  logic                 join_i,
   input  logic                 emit_i,
   input  ftype_e               kind_i,
   input  logic [ID_W-1:0]      src_i,
   input  logic [TS_W-1:0]      ts_i,
   output wstate_e              state_o,
   output ftype_e               kind_o,
   output logic [ID_W-1:0]      src_o,
   output logic [TS_W-1:0]      ts_o,
   output logic [(1<<ID_W)-1:0] mask_o
);
   localparam int MASK_W = 1 << ID_W;
   localparam int CNT_W  = $clog2(WIN_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [MASK_W-1:0] bit_in;

   assign bit_in = MASK_W'(1) << src_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_o <= WS_IDLE;
         kind_o  <= FT_SYNC;
         src_o   <= '0;
         ts_o    <= '0;
         mask_o  <= '0;
         cnt_q   <= '0;
      end else begin
         unique case (state_o)
            WS_IDLE: if (open_i) begin
               state_o <= WS_OPEN;
               kind_o  <= kind_i;
               src_o   <= src_i;
               ts_o    <= ts_i;
               mask_o  <= bit_in;
               cnt_q   <= '0;
            end
            WS_OPEN: begin
               if (join_i) mask_o <= mask_o | bit_in;
               if (cnt_q == LAST) state_o <= WS_EMIT;
               else               cnt_q   <= cnt_q + 1'b1;
            end
            WS_EMIT: if (emit_i) begin
               state_o <= WS_IDLE;
               mask_o  <= '0;
            end
            default: state_o <= WS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfc_slot.sv
module cfc_slot #(
   parameter int FW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [FW-1:0] data_i,
   input  logic          ready_i,
   output logic          valid_o,
   output logic [FW-1:0] data_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         data_o  <= data_i;
      end else if (ready_i) begin
         valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/cfcompress_fwd.sv
module cfcompress_fwd import cfc_pkg::*; #(
   parameter int NPORTS     = 4,
   parameter int ID_W       = 3,
   parameter int TS_W       = 16,
   parameter int WIN_CYCLES = 8,
   parameter bit LOW_FIRST  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          mode_single,
   input  logic [NPORTS-1:0]             in_valid,
   output logic [NPORTS-1:0]             in_ready,
   input  logic [NPORTS*TYPE_W-1:0]      in_type,
   input  logic [NPORTS*ID_W-1:0]        in_src,
   input  logic [NPORTS*TS_W-1:0]        in_ts,
   output logic [NPORTS-1:0]             out_valid,
   input  logic [NPORTS-1:0]             out_ready,
   output logic [NPORTS*TYPE_W-1:0]      out_type,
   output logic [NPORTS*ID_W-1:0]        out_src,
   output logic [NPORTS*TS_W-1:0]        out_ts,
   output logic [NPORTS*(1<<ID_W)-1:0]   out_mask
);
   localparam int MASK_W = 1 << ID_W;
   localparam int IDX_W  = $clog2(NPORTS);
   localparam int FW     = TYPE_W + ID_W + TS_W + MASK_W;

   if (NPORTS < 2)      begin : g_bad_ports $error("NPORTS must be at least 2"); end
   if (WIN_CYCLES < 2)  begin : g_bad_win   $error("WIN_CYCLES must be at least 2"); end
   if (ID_W < 1 || ID_W > 8) begin : g_bad_id $error("ID_W out of range"); end
   if (TS_W < 1)        begin : g_bad_ts    $error("TS_W must be positive"); end

   logic             sel_v;
   logic [IDX_W-1:0] sel_i;
   logic [TYPE_W-1:0] sel_type_raw;
   ftype_e           sel_type;
   logic [ID_W-1:0]  sel_src;
   logic [TS_W-1:0]  sel_ts;

   cfc_pick #(.N(NPORTS), .IDX_W(IDX_W), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req_i (in_valid),
      .vld_o (sel_v),
      .idx_o (sel_i)
   );

   always_comb begin
      sel_type_raw = '0;
      sel_src      = '0;
      sel_ts       = '0;
      for (int p = 0; p < NPORTS; p++) begin
         if (IDX_W'(p) == sel_i) begin
            sel_type_raw = in_type[p*TYPE_W +: TYPE_W];
            sel_src      = in_src[p*ID_W +: ID_W];
            sel_ts       = in_ts[p*TS_W +: TS_W];
         end
      end
   end
   assign sel_type = ftype_e'(sel_type_raw);

   // window state and latched mode
   wstate_e           w_state;
   ftype_e            w_kind;
   logic [ID_W-1:0]   w_src;
   logic [TS_W-1:0]   w_ts;
   logic [MASK_W-1:0] w_mask;
   logic              mode_q;
   logic              eff_single;

   assign eff_single = (w_state == WS_IDLE) ? mode_single : mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 mode_q <= 1'b0;
      else if (w_state == WS_IDLE) mode_q <= mode_single;
   end

   // routing decision for the selected ingress frame
   logic is_fwd, is_cmp, is_drop, others_free, all_free;
   logic emit_go, acc_open, acc_join, acc_fwd, accept;

   assign is_fwd  = (sel_type == FT_CSTART) || (sel_type == FT_CACK && !eff_single);
   assign is_cmp  = (sel_type == FT_SYNC)   || (sel_type == FT_CACK &&  eff_single);
   assign is_drop = (sel_type == FT_OTHER);

   always_comb begin
      others_free = 1'b1;
      for (int p = 0; p < NPORTS; p++)
         if (IDX_W'(p) != sel_i && out_valid[p]) others_free = 1'b0;
   end
   assign all_free = ~|out_valid;

   assign emit_go  = (w_state == WS_EMIT) && all_free;
   assign acc_open = sel_v && is_cmp && (w_state == WS_IDLE);
   assign acc_join = sel_v && is_cmp && (w_state == WS_OPEN) && (sel_type == w_kind);
   assign acc_fwd  = sel_v && is_fwd && others_free && !emit_go;
   assign accept   = sel_v && (is_drop || acc_open || acc_join || acc_fwd);

   always_comb begin
      in_ready = '0;
      for (int p = 0; p < NPORTS; p++)
         if (IDX_W'(p) == sel_i) in_ready[p] = accept;
   end

   cfc_window #(.ID_W(ID_W), .TS_W(TS_W), .WIN_CYCLES(WIN_CYCLES)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_i  (acc_open),
      .join_i  (acc_join),
      .emit_i  (emit_go),
      .kind_i  (sel_type),
      .src_i   (sel_src),
      .ts_i    (sel_ts),
      .state_o (w_state),
      .kind_o  (w_kind),
      .src_o   (w_src),
      .ts_o    (w_ts),
      .mask_o  (w_mask)
   );

   logic [FW-1:0] comp_word, fwd_word, load_word;
   assign comp_word = {w_kind, w_src, w_ts, w_mask};
   assign fwd_word  = {sel_type, sel_src, sel_ts, MASK_W'(1) << sel_src};
   assign load_word = emit_go ? comp_word : fwd_word;

   for (genvar p = 0; p < NPORTS; p++) begin : g_egr
      logic          load;
      logic [FW-1:0] word;

      assign load = emit_go || (acc_fwd && IDX_W'(p) != sel_i);

      cfc_slot #(.FW(FW)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_i  (load),
         .data_i  (load_word),
         .ready_i (out_ready[p]),
         .valid_o (out_valid[p]),
         .data_o  (word)
      );

      assign {out_type[p*TYPE_W +: TYPE_W], out_src[p*ID_W +: ID_W],
              out_ts[p*TS_W +: TS_W], out_mask[p*MASK_W +: MASK_W]} = word;
   end
endmodule

// File: rtl/cfc_fwd_chk.sv
module cfc_fwd_chk import cfc_pkg::*; #(
   parameter int NPORTS = 4,
   parameter int ID_W   = 3,
   parameter int TS_W   = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NPORTS-1:0]           in_valid,
   input logic [NPORTS-1:0]           in_ready,
   input logic [NPORTS*TYPE_W-1:0]    in_type,
   input logic [NPORTS-1:0]           out_valid,
   input logic [NPORTS-1:0]           out_ready,
   input logic [NPORTS*TYPE_W-1:0]    out_type,
   input logic [NPORTS*ID_W-1:0]      out_src,
   input logic [NPORTS*TS_W-1:0]      out_ts,
   input logic [NPORTS*(1<<ID_W)-1:0] out_mask
);
   localparam int MASK_W = 1 << ID_W;

   // R10
   ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready));

   // R6
   sync_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[0] && !$past(out_valid[0]) && out_type[TYPE_W-1:0] == FT_SYNC)
      |-> (&out_valid));

   for (genvar p = 0; p < NPORTS; p++) begin : g_p
      // R9
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[p] && !out_ready[p]) |=>
         (out_valid[p] && $stable(out_type[p*TYPE_W +: TYPE_W])
          && $stable(out_src[p*ID_W +: ID_W]) && $stable(out_ts[p*TS_W +: TS_W])
          && $stable(out_mask[p*MASK_W +: MASK_W])));

      for (genvar q = 0; q < NPORTS; q++) begin : g_q
         if (q != p) begin : g_other
            // R2
            cs_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (in_valid[p] && in_ready[p] && in_type[p*TYPE_W +: TYPE_W] == FT_CSTART)
               |=> (out_valid[q] && out_type[q*TYPE_W +: TYPE_W] == FT_CSTART));
         end
      end
   end
endmodule

bind cfcompress_fwd cfc_fwd_chk #(.NPORTS(NPORTS), .ID_W(ID_W), .TS_W(TS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_type   (in_type),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_type  (out_type),
   .out_src   (out_src),
   .out_ts    (out_ts),
   .out_mask  (out_mask)
);

// File: tb/test_cfcompress_fwd.sv
module test_cfcompress_fwd;
   localparam int NP = 4;
   localparam int IW = 3;
   localparam int TW = 16;
   localparam int MW = 1 << IW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_single = 1'b0;
   logic [NP-1:0]    in_valid = '0;
   logic [NP-1:0]    in_ready;
   logic [NP*2-1:0]  in_type = '0;
   logic [NP*IW-1:0] in_src = '0;
   logic [NP*TW-1:0] in_ts = '0;
   logic [NP-1:0]    out_valid;
   logic [NP-1:0]    out_ready = '0;
   logic [NP*2-1:0]  out_type;
   logic [NP*IW-1:0] out_src;
   logic [NP*TW-1:0] out_ts;
   logic [NP*MW-1:0] out_mask;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cfcompress_fwd #(.NPORTS(NP), .ID_W(IW), .TS_W(TW), .WIN_CYCLES(8)) i_cfcompress_fwd (
      .clk(clk), .rst_n(rst_n), .mode_single(mode_single),
      .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
      .in_src(in_src), .in_ts(in_ts),
      .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
      .out_src(out_src), .out_ts(out_ts), .out_mask(out_mask)
   );

   function automatic logic [1:0]    ot(int p); return out_type[p*2 +: 2];   endfunction
   function automatic logic [IW-1:0] os(int p); return out_src[p*IW +: IW];  endfunction
   function automatic logic [TW-1:0] ots(int p); return out_ts[p*TW +: TW];  endfunction
   function automatic logic [MW-1:0] om(int p); return out_mask[p*MW +: MW]; endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input longint act, input longint exp);
      check(act == exp, req, act, exp);
   endtask

   task automatic put(input int p, input logic [1:0] t, input int s, input int ts);
      in_type[p*2 +: 2]   = t;
      in_src[p*IW +: IW]  = IW'(s);
      in_ts[p*TW +: TW]   = TW'(ts);
      in_valid[p]         = 1'b1;
   endtask

   task automatic acc(input int p, output bit ok);
      ok = 0;
      for (int k = 0; k < 60; k++) begin
         #1;
         if (in_ready[p]) begin
            @(posedge clk);
            @(negedge clk);
            in_valid[p] = 1'b0;
            ok = 1;
            break;
         end
         @(negedge clk);
      end
      if (!ok) in_valid[p] = 1'b0;
   endtask

   task automatic send(input int p, input logic [1:0] t, input int s, input int ts, input string req);
      bit ok;
      put(p, t, s, ts);
      acc(p, ok);
      check(ok, req, 0, 1);
   endtask

   task automatic drain();
      out_ready = '1;
      @(negedge clk);
      out_ready = '0;
   endtask

   task automatic wait_out(input int p, input string req);
      bit seen = 0;
      for (int k = 0; k < 40; k++) begin
         if (out_valid[p]) begin seen = 1; break; end
         @(negedge clk);
      end
      check(seen, req, 0, 1);
   endtask

   task automatic t_reset();
      chk_eq("R1 out_valid", out_valid, 0);
      chk_eq("R1 in_ready", in_ready, 0);
   endtask

   task automatic t_cstart();
      send(2, 2'd1, 5, 'h1234, "R2 accept");
      chk_eq("R2 fanout", out_valid, 4'b1011);
      chk_eq("R2 type", ot(0), 1);
      chk_eq("R2 src", os(3), 5);
      chk_eq("R2 ts", ots(1), 'h1234);
      chk_eq("R2 mask", om(0), 'h20);
      drain();
   endtask

   task automatic t_ack_multi();
      mode_single = 1'b0;
      send(1, 2'd2, 3, 'h55, "R3 accept");
      chk_eq("R3 fanout", out_valid, 4'b1101);
      chk_eq("R3 type", ot(2), 2);
      chk_eq("R3 src", os(0), 3);
      drain();
   endtask

   task automatic t_ack_single();
      mode_single = 1'b1;
      send(0, 2'd2, 1, 'h100, "R4 accept a");
      send(3, 2'd2, 6, 'h200, "R4 accept b");
      send(2, 2'd2, 2, 'h300, "R4 accept c");
      chk_eq("R4 no copy", out_valid, 0);
      wait_out(0, "R4 emitted");
      chk_eq("R4 all ports", out_valid, 4'b1111);
      chk_eq("R4 type", ot(1), 2);
      chk_eq("R4 src", os(2), 1);
      chk_eq("R4 ts", ots(0), 'h100);
      chk_eq("R4 mask p0", om(0), 'h46);
      chk_eq("R4 mask p3", om(3), 'h46);
      drain();
   endtask

   task automatic t_window();
      mode_single = 1'b1;
      send(1, 2'd2, 4, 1, "R5 accept first");
      repeat (8) @(negedge clk);
      chk_eq("R5 not yet", out_valid, 0);
      @(negedge clk);
      chk_eq("R5 close edge", out_valid, 4'b1111);
      send(2, 2'd2, 7, 2, "R5 accept late");
      chk_eq("R5 first mask", om(0), 'h10);
      drain();
      wait_out(0, "R5 second emitted");
      chk_eq("R5 second mask", om(1), 'h80);
      chk_eq("R5 second ts", ots(1), 2);
      drain();
   endtask

   task automatic t_sync();
      mode_single = 1'b0;
      send(0, 2'd0, 0, 7, "R6 accept a");
      send(1, 2'd0, 2, 8, "R6 accept b");
      chk_eq("R6 no copy", out_valid, 0);
      wait_out(0, "R6 emitted");
      chk_eq("R6 all ports", out_valid, 4'b1111);
      chk_eq("R6 type", ot(3), 0);
      chk_eq("R6 mask", om(2), 'h05);
      chk_eq("R6 ts", ots(0), 7);
      drain();
   endtask

   task automatic t_other();
      send(3, 2'd3, 2, 9, "R7 accept");
      repeat (12) @(negedge clk);
      chk_eq("R7 dropped", out_valid, 0);
   endtask

   task automatic t_mode();
      mode_single = 1'b1;
      send(1, 2'd2, 1, 'h40, "R8 accept a");
      mode_single = 1'b0;
      send(2, 2'd2, 2, 'h41, "R8 accept b");
      chk_eq("R8 still merging", out_valid, 0);
      wait_out(0, "R8 emitted");
      chk_eq("R8 all ports", out_valid, 4'b1111);
      chk_eq("R8 mask", om(0), 'h06);
      drain();
      send(2, 2'd2, 3, 'h42, "R8 accept c");
      chk_eq("R8 new mode copies", out_valid, 4'b1011);
      drain();
   endtask

   task automatic t_backpressure();
      bit ok;
      send(0, 2'd1, 1, 11, "R9 accept first");
      chk_eq("R9 first fanout", out_valid, 4'b1110);
      put(2, 2'd1, 2, 12);
      repeat (5) @(negedge clk);
      #1;
      chk_eq("R9 stalled", in_ready[2], 0);
      chk_eq("R9 held src", os(1), 1);
      chk_eq("R9 held ts", ots(3), 11);
      @(negedge clk);
      drain();
      acc(2, ok);
      check(ok, "R9 accept after drain", 0, 1);
      chk_eq("R9 second fanout", out_valid, 4'b1011);
      chk_eq("R9 second src", os(0), 2);
      drain();
   endtask

   task automatic t_arb();
      bit ok;
      put(1, 2'd1, 1, 21);
      put(2, 2'd1, 2, 22);
      acc(1, ok);
      check(ok, "R10 low port first", 0, 1);
      chk_eq("R10 winner src", os(0), 1);
      chk_eq("R10 fanout", out_valid, 4'b1101);
      #1;
      chk_eq("R10 loser waits", in_ready[2], 0);
      @(negedge clk);
      drain();
      acc(2, ok);
      check(ok, "R10 loser served", 0, 1);
      chk_eq("R10 loser src", os(0), 2);
      drain();
   endtask

   task automatic t_kind();
      bit ok;
      mode_single = 1'b1;
      send(0, 2'd2, 0, 'h30, "R11 accept ack");
      put(3, 2'd0, 5, 'h31);
      #1;
      chk_eq("R11 sync waits", in_ready[3], 0);
      @(negedge clk);
      wait_out(0, "R11 ack emitted");
      chk_eq("R11 ack type", ot(0), 2);
      chk_eq("R11 ack mask", om(0), 'h01);
      acc(3, ok);
      check(ok, "R11 sync accepted after", 0, 1);
      drain();
      wait_out(0, "R11 sync emitted");
      chk_eq("R11 sync type", ot(2), 0);
      chk_eq("R11 sync mask", om(2), 'h20);
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cstart();
      t_ack_multi();
      t_ack_single();
      t_window();
      t_sync();
      t_other();
      t_mode();
      t_backpressure();
      t_arb();
      t_kind();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule